// File: doc/BRIEF.md
# Tributary Output Selector with Alarm Indication Insertion

This block decides, for every demultiplexed tributary leaving a two-stage demultiplexer, whether the output carries the recovered data, an all-ones alarm indication signal (AIS), or a constant low. Each group of tributaries has one second-level output and four first-level lane outputs. The second-level output chooses between idle-low, AIS and data. The four lanes choose between AIS and data, and a per-group type bit sets the lanes to DS1 or E1 operation. In E1 operation the fourth lane of the group is unused and is held low.

Failures detected at higher multiplex levels force AIS without software action. A top-level failure forces all-ones on every output that is not idle or held low. A per-group failure forces all-ones on that group's four lanes only. Each output is then retimed by its own tributary clock, on the rising or falling edge as its edge bit selects. Tributary clocks are sampled as levels in the system clock domain, and a transition of the selected polarity loads the output register.

Top module: `tos_top`

## Requirements
- R1: When a group's idle bit is 1, its second-level output is low, whatever its AIS bit, its data and the top-level failure input.
- R2: When a group's idle bit is 0, its second-level output carries the group's second-level data if its AIS bit is 0, and all-ones if its AIS bit is 1.
- R3: While the top-level failure input is 1, every second-level output that is not idle and every lane that is not an E1 fourth lane carries all-ones.
- R4: While a group's failure input is 1, all four lanes of that group carry all-ones unless held low by R6. Lanes of other groups and all second-level outputs are not affected by it.
- R5: A lane carries its data when its AIS bit is 0 and no failure input applies to it, and all-ones when its AIS bit is 1.
- R6: Lane index g*4+k belongs to group g, with k = 0..3. Group type bit 1 selects DS1 and 0 selects E1. In E1 the lane with k = 3 is low regardless of its AIS bit, its data and any failure input.
- R7: An output's edge bit set to 1 selects the rising edge and 0 the falling edge of its own tributary clock. The output changes only in the system clock cycle where a transition of the selected polarity is first sampled. It then takes the selection registered on the system clock edge before.
- R8: While reset is high, and after it until the first selected clock edge, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_data | input | NUM_GRP | Demultiplexed second-level data per group |
| hi_tclk | input | NUM_GRP | Second-level tributary clock per group (sampled level) |
| hi_idle | input | NUM_GRP | Hold second-level output low |
| hi_ais | input | NUM_GRP | Force second-level output to all-ones |
| hi_rise | input | NUM_GRP | Second-level retime edge: 1 rising, 0 falling |
| lo_data | input | NUM_GRP*4 | Demultiplexed lane data, lane g*4+k |
| lo_tclk | input | NUM_GRP*4 | Lane tributary clocks (sampled level) |
| lo_ais | input | NUM_GRP*4 | Force lane to all-ones |
| lo_rise | input | NUM_GRP*4 | Lane retime edge: 1 rising, 0 falling |
| grp_ds1 | input | NUM_GRP | Group type: 1 DS1, 0 E1 |
| fail_top | input | 1 | Top-level failure requesting automatic AIS everywhere |
| fail_grp | input | NUM_GRP | Group-level failure requesting AIS on that group's lanes |
| hi_out | output | NUM_GRP | Retimed second-level outputs |
| lo_out | output | NUM_GRP*4 | Retimed lane outputs |

## Verification
A new selection is registered on the first system clock edge after the controls change. It reaches an output only on the clock edge where a tributary clock transition of the selected polarity is sampled, so the result can appear one cycle after the stimulus at the earliest. The bench therefore changes controls and data first and waits three cycles with the tributary clocks held still. There it checks that every output still shows the previous expected value. It then makes the selected transition, waits three more cycles and compares every output with the value worked out from the priority of low-hold, AIS and data. Controls are never changed on the same edge as a tributary clock, so the one-cycle selection register cannot blur the result.

// File: rtl/tos_pkg.sv
package tos_pkg;

    localparam int LANES_PER_GRP = 4;

    typedef enum logic [1:0] {
        SRC_LOW  = 2'd0,
        SRC_DATA = 2'd1,
        SRC_ONES = 2'd2
    } src_e;

    typedef struct packed {
        logic idle;
        logic ais;
        logic auto_ais;
        logic data;
    } hi_ctl_t;

    typedef struct packed {
        logic e1_last;
        logic ais;
        logic auto_ais;
        logic data;
    } lo_ctl_t;

    function automatic src_e pick_hi(input hi_ctl_t c);
        if (c.idle)                 return SRC_LOW;
        else if (c.ais || c.auto_ais) return SRC_ONES;
        else                        return SRC_DATA;
    endfunction

    function automatic src_e pick_lo(input lo_ctl_t c);
        if (c.e1_last)              return SRC_LOW;
        else if (c.ais || c.auto_ais) return SRC_ONES;
        else                        return SRC_DATA;
    endfunction

    function automatic logic src_bit(input src_e s, input logic data);
        case (s)
            SRC_ONES: return 1'b1;
            SRC_DATA: return data;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tos_hi_sel.sv
module tos_hi_sel
    import tos_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hi_ctl_t ctl,
    output logic    bit_q
);

    src_e src;

    always_comb begin
        src = pick_hi(ctl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= src_bit(src, ctl.data);
        end
    end

    AST_HI_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        ctl.idle |=> !bit_q); // R1
    AST_HI_AIS_ONES: assert property (@(posedge clk) disable iff (rst)
        (!ctl.idle && ctl.ais) |=> bit_q); // R2
    AST_HI_AUTO_ONES: assert property (@(posedge clk) disable iff (rst)
        (!ctl.idle && ctl.auto_ais) |=> bit_q); // R3
    AST_HI_PASS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.idle && !ctl.ais && !ctl.auto_ais) |=> (bit_q == $past(ctl.data))); // R2

endmodule

// File: rtl/tos_lo_sel.sv
module tos_lo_sel
    import tos_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lo_ctl_t ctl,
    output logic    bit_q
);

    src_e src;

    always_comb begin
        src = pick_lo(ctl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= src_bit(src, ctl.data);
        end
    end

    AST_LO_E1_LAST_LOW: assert property (@(posedge clk) disable iff (rst)
        ctl.e1_last |=> !bit_q); // R6
    AST_LO_AIS_ONES: assert property (@(posedge clk) disable iff (rst)
        (!ctl.e1_last && (ctl.ais || ctl.auto_ais)) |=> bit_q); // R5
    AST_LO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.e1_last && !ctl.ais && !ctl.auto_ais) |=> (bit_q == $past(ctl.data))); // R5

endmodule

// File: rtl/tos_retime.sv
module tos_retime (
    input  logic clk,
    input  logic rst,
    input  logic tclk,
    input  logic use_rise,
    input  logic sel_bit,
    output logic dout
);

    logic tclk_prev;
    logic fire;

    always_comb begin
        if (use_rise) fire = tclk & ~tclk_prev;
        else          fire = ~tclk & tclk_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tclk_prev <= 1'b0;
            dout      <= 1'b0;
        end else begin
            tclk_prev <= tclk;
            if (fire) dout <= sel_bit;
        end
    end

    AST_RT_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(dout)); // R7
    AST_RT_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        fire |=> (dout == $past(sel_bit))); // R7
    AST_RT_RESET_LOW: assert property (@(posedge clk)
        rst |=> !dout); // R8

endmodule

// File: rtl/tos_top.sv
module tos_top
    import tos_pkg::*;
#(
    parameter int NUM_GRP = 7,
    localparam int NUM_LANE = NUM_GRP * LANES_PER_GRP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GRP-1:0]  hi_data,
    input  logic [NUM_GRP-1:0]  hi_tclk,
    input  logic [NUM_GRP-1:0]  hi_idle,
    input  logic [NUM_GRP-1:0]  hi_ais,
    input  logic [NUM_GRP-1:0]  hi_rise,
    input  logic [NUM_LANE-1:0] lo_data,
    input  logic [NUM_LANE-1:0] lo_tclk,
    input  logic [NUM_LANE-1:0] lo_ais,
    input  logic [NUM_LANE-1:0] lo_rise,
    input  logic [NUM_GRP-1:0]  grp_ds1,
    input  logic                fail_top,
    input  logic [NUM_GRP-1:0]  fail_grp,
    output logic [NUM_GRP-1:0]  hi_out,
    output logic [NUM_LANE-1:0] lo_out
);

    logic [NUM_GRP-1:0]  hi_sel_q;
    logic [NUM_LANE-1:0] lo_sel_q;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        hi_ctl_t hctl;

        always_comb begin
            hctl.idle     = hi_idle[g];
            hctl.ais      = hi_ais[g];
            hctl.auto_ais = fail_top;
            hctl.data     = hi_data[g];
        end

        tos_hi_sel u_hsel (
            .clk   (clk),
            .rst   (rst),
            .ctl   (hctl),
            .bit_q (hi_sel_q[g])
        );

        tos_retime u_hrt (
            .clk      (clk),
            .rst      (rst),
            .tclk     (hi_tclk[g]),
            .use_rise (hi_rise[g]),
            .sel_bit  (hi_sel_q[g]),
            .dout     (hi_out[g])
        );

        for (genvar k = 0; k < LANES_PER_GRP; k++) begin : g_lane
            localparam int L = g * LANES_PER_GRP + k;
            lo_ctl_t lctl;

            always_comb begin
                lctl.e1_last  = !grp_ds1[g] && (k == LANES_PER_GRP - 1);
                lctl.ais      = lo_ais[L];
                lctl.auto_ais = fail_top | fail_grp[g];
                lctl.data     = lo_data[L];
            end

            tos_lo_sel u_lsel (
                .clk   (clk),
                .rst   (rst),
                .ctl   (lctl),
                .bit_q (lo_sel_q[L])
            );

            tos_retime u_lrt (
                .clk      (clk),
                .rst      (rst),
                .tclk     (lo_tclk[L]),
                .use_rise (lo_rise[L]),
                .sel_bit  (lo_sel_q[L]),
                .dout     (lo_out[L])
            );
        end
    end

    AST_TOP_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (hi_out == '0 && lo_out == '0)); // R8

endmodule

// File: tb/sim_tos_top.sv
module sim_tos_top;

    localparam int NG = 2;
    localparam int NL = NG * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NG-1:0] hi_data = '0, hi_tclk = '0, hi_idle = '0, hi_ais = '0, hi_rise = '0;
    logic [NL-1:0] lo_data = '0, lo_tclk = '0, lo_ais = '0, lo_rise = '0;
    logic [NG-1:0] grp_ds1 = '1, fail_grp = '0;
    logic          fail_top = 1'b0;
    logic [NG-1:0] hi_out;
    logic [NL-1:0] lo_out;

    int n_run  = 0;
    int n_fail = 0;
    logic [NG-1:0] exp_hi, prev_hi;
    logic [NL-1:0] exp_lo, prev_lo;
    string hi_tag [NG];
    string lo_tag [NL];

    always #2.5 clk = ~clk;

    tos_top #(.NUM_GRP(NG)) u0 (
        .clk(clk), .rst(rst),
        .hi_data(hi_data), .hi_tclk(hi_tclk), .hi_idle(hi_idle),
        .hi_ais(hi_ais), .hi_rise(hi_rise),
        .lo_data(lo_data), .lo_tclk(lo_tclk), .lo_ais(lo_ais), .lo_rise(lo_rise),
        .grp_ds1(grp_ds1), .fail_top(fail_top), .fail_grp(fail_grp),
        .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic check_bit(input logic act, input logic exp, input string tag,
                             input string what, input int idx);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s[%0d] actual=%b expected=%b", tag, what, idx, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        // R8: outputs low during reset
        wait_cyc(3);
        for (int g = 0; g < NG; g++) check_bit(hi_out[g], 1'b0, "R8", "hi_out", g);
        for (int l = 0; l < NL; l++) check_bit(lo_out[l], 1'b0, "R8", "lo_out", l);
        rst = 1'b0;
        // R8: still low after reset with controls pending and no clock edge
        hi_data = '1; lo_data = '1;
        wait_cyc(3);
        for (int g = 0; g < NG; g++) check_bit(hi_out[g], 1'b0, "R8", "hi_out", g);
        for (int l = 0; l < NL; l++) check_bit(lo_out[l], 1'b0, "R8", "lo_out", l);
        prev_hi = '0;
        prev_lo = '0;

        for (int i = 0; i < 256; i++) begin
            logic idle, hais, ftop, fg0, ds1g0, lais, pol, rise;
            idle  = i[0]; hais = i[1]; ftop = i[2]; fg0 = i[3];
            ds1g0 = i[4]; lais = i[5]; pol  = i[6]; rise = i[7];

            // step 1: tributary clocks to the inactive level of the new edge
            hi_tclk = rise ? '0 : '1;
            lo_tclk = rise ? '0 : '1;
            wait_cyc(3);

            // step 2: new controls, no tributary clock movement
            hi_rise  = {NG{rise}};
            lo_rise  = {NL{rise}};
            hi_idle  = {~idle, idle};
            hi_ais   = {~hais, hais};
            hi_data  = {pol, ~pol};
            fail_top = ftop;
            fail_grp = {1'b0, fg0};
            grp_ds1  = {~ds1g0, ds1g0};
            lo_ais   = lais ? 8'b1010_0101 : 8'b0101_1010;
            lo_data  = pol ? 8'hC3 : 8'h3C;

            for (int g = 0; g < NG; g++) begin
                if (hi_idle[g]) begin
                    exp_hi[g] = 1'b0; hi_tag[g] = "R1";
                end else if (hi_ais[g]) begin
                    exp_hi[g] = 1'b1; hi_tag[g] = "R2";
                end else if (fail_top) begin
                    exp_hi[g] = 1'b1; hi_tag[g] = "R3";
                end else begin
                    exp_hi[g] = hi_data[g]; hi_tag[g] = "R2";
                end
            end
            for (int l = 0; l < NL; l++) begin
                int g, k;
                g = l / 4; k = l % 4;
                if (!grp_ds1[g] && k == 3) begin
                    exp_lo[l] = 1'b0; lo_tag[l] = "R6";
                end else if (lo_ais[l]) begin
                    exp_lo[l] = 1'b1; lo_tag[l] = "R5";
                end else if (fail_top) begin
                    exp_lo[l] = 1'b1; lo_tag[l] = "R3";
                end else if (fail_grp[g]) begin
                    exp_lo[l] = 1'b1; lo_tag[l] = "R4";
                end else begin
                    exp_lo[l] = lo_data[l]; lo_tag[l] = "R5";
                end
            end
            wait_cyc(3);
            // R7: no selected edge yet, outputs keep the previous value
            for (int g = 0; g < NG; g++) check_bit(hi_out[g], prev_hi[g], "R7", "hi_out hold", g);
            for (int l = 0; l < NL; l++) check_bit(lo_out[l], prev_lo[l], "R7", "lo_out hold", l);

            // step 3: selected tributary clock transition
            hi_tclk = ~hi_tclk;
            lo_tclk = ~lo_tclk;
            wait_cyc(3);
            for (int g = 0; g < NG; g++) check_bit(hi_out[g], exp_hi[g], hi_tag[g], "hi_out", g);
            for (int l = 0; l < NL; l++) check_bit(lo_out[l], exp_lo[l], lo_tag[l], "lo_out", l);
            prev_hi = exp_hi;
            prev_lo = exp_lo;
        end

        // R7: the non-selected transition leaves outputs unchanged
        hi_rise = '1; lo_rise = '1;
        hi_tclk = '1; lo_tclk = '1;
        wait_cyc(3);
        hi_idle = '0; hi_ais = '0; fail_top = 1'b0; fail_grp = '0; grp_ds1 = '1;
        lo_ais = '0; hi_data = ~prev_hi; lo_data = ~prev_lo;
        wait_cyc(3);
        hi_tclk = '0; lo_tclk = '0;
        wait_cyc(3);
        for (int g = 0; g < NG; g++) check_bit(hi_out[g], prev_hi[g], "R7", "hi_out falling ignored", g);
        for (int l = 0; l < NL; l++) check_bit(lo_out[l], prev_lo[l], "R7", "lo_out falling ignored", l);
        hi_tclk = '1; lo_tclk = '1;
        wait_cyc(3);
        for (int g = 0; g < NG; g++) check_bit(hi_out[g], ~prev_hi[g], "R7", "hi_out rising taken", g);
        for (int l = 0; l < NL; l++) check_bit(lo_out[l], ~prev_lo[l], "R7", "lo_out rising taken", l);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule